// File: doc/BRIEF.md
# Four-Bank SDRAM Read Command Sequencer

This block accepts single-word read requests and turns them into a command stream for a synchronous memory with four banks. Each request names a bank, a row, a column and a tag. The sequencer keeps a record of which row is open in each bank. A request that hits an open row goes straight to a READ. A request to a closed bank gets an ACTIVATE first. A request that conflicts with the open row forces a PRECHARGE and then a fresh ACTIVATE. Work on one bank is interleaved with the timing gaps of the others. At most one command is driven per cycle, so the bus stays as busy as the rules allow.

Requests enter a small in-order queue over a valid/ready handshake. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. The producer must hold its fields stable while `req_ready` is low. The scheduler only considers the oldest queued request of each bank, so requests to the same bank are served in arrival order. Requests to different banks may finish out of order. Each result comes back with the tag of its request.

The response side has no ready input, so the consumer must take every `rsp_valid` beat. When the queue drains, the block closes every open bank and raises `idle`.

Top module: `sdram_seq`

## Requirements
- R1: `req_ready` is low exactly when the queue already holds QDEPTH (default 4) requests that have not yet been read. A request is accepted on an edge where `req_valid` and `req_ready` are both high.
- R2: `cmd_o` uses the encoding 0 = NOP, 1 = ACTIVATE, 2 = READ, 3 = PRECHARGE. `cmd_bank_o` names the bank. `cmd_addr_o` carries the row on ACTIVATE and the column on READ. At most one command is issued per cycle, and ACTIVATE only goes to a closed bank.
- R3: A READ to a bank comes at least 2 cycles after the ACTIVATE of that bank.
- R4: A PRECHARGE to a bank comes at least 3 cycles after the last READ of that bank, leaving two full cycles in between.
- R5: A READ only goes to an open bank whose open row equals the request's row. Reads to an already open row need no further ACTIVATE.
- R6: A request whose row differs from the open row of its bank causes a PRECHARGE of that bank and then an ACTIVATE of the new row. An ACTIVATE may follow the PRECHARGE in the very next cycle. PRECHARGE only goes to an open bank.
- R7: When several requests could issue a command, the oldest one wins. Within one bank, reads are issued in arrival order.
- R8: Read data arrives on `rd_data_i` in the cycle after its READ. It is presented on `rsp_data` with the request's tag on `rsp_tag`, with `rsp_valid` high for one cycle, two cycles after the READ cycle.
- R9: When the queue is empty, each open bank is precharged as soon as R4 allows, lowest bank first. `idle` is high exactly when the queue is empty and no bank is open.
- R10: NOP is driven only when no legal command exists. This gives these command spans from first to last command inclusive:
  - 24 cycles for four rows of bank 0.
  - 9 cycles for two same-row reads in each of banks 0 and 1, arriving alternately.
  - 12 cycles for one read in each of the four banks.
- R11: During and after reset, `cmd_o` is NOP, `idle` and `req_ready` are high, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room |
| req_bank | input | 2 | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| req_tag | input | TAG_W | Request tag |
| cmd_o | output | 2 | Memory command |
| cmd_bank_o | output | 2 | Command bank |
| cmd_addr_o | output | ADDR_W | Row or column address |
| rd_data_i | input | DATA_W | Read data from memory |
| rsp_valid | output | 1 | Result strobe |
| rsp_tag | output | TAG_W | Tag of the result |
| rsp_data | output | DATA_W | Result word |
| idle | output | 1 | Queue empty, all banks closed |

## Verification
The bound checker keeps its own record of the open banks from the command stream. On every cycle it checks:
- no ACTIVATE goes to an open bank;
- no READ or PRECHARGE goes to a closed bank;
- the ACTIVATE-to-READ and READ-to-PRECHARGE gaps are respected;
- each result strobe lines up with a READ two cycles earlier;
- `idle` never coexists with an open bank.

Only the bench scenarios can show the rest:
- that the schedule is as tight as the rules allow (the exact command spans);
- that the oldest request wins;
- that the right row and column are used for each tag;
- that back-pressure appears exactly when the queue is full.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  localparam int NBANK  = 4;
  localparam int BANK_W = 2;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } sdq_cmd_e;
endpackage

// File: rtl/sdq_bank.sv
// State of one bank: open flag, open row and the two gap counters.
module sdq_bank #(
  parameter int ROW_W    = 4,
  parameter int T_ACT_RD = 2,
  parameter int T_RD_PRE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_rd,
  input  logic             do_pre,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             rd_ok,
  output logic             pre_ok
);
  localparam int TMAX = (T_ACT_RD > T_RD_PRE) ? T_ACT_RD : T_RD_PRE;
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] act_wait;
  logic [CW-1:0] pre_wait;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
      act_wait <= '0;
      pre_wait <= '0;
    end else if (do_act) begin
      is_open  <= 1'b1;
      open_row <= act_row;
      act_wait <= CW'(T_ACT_RD - 1);
      pre_wait <= '0;
    end else if (do_pre) begin
      is_open  <= 1'b0;
      act_wait <= '0;
      pre_wait <= '0;
    end else begin
      if (act_wait != '0) act_wait <= act_wait - 1'b1;
      if (do_rd) pre_wait <= CW'(T_RD_PRE - 1);
      else if (pre_wait != '0) pre_wait <= pre_wait - 1'b1;
    end
  end

  assign rd_ok  = is_open && (act_wait == '0);
  assign pre_ok = is_open && (pre_wait == '0);
endmodule

// File: rtl/sdq_queue.sv
// In-order request store; any entry may leave, younger ones close the gap.
module sdq_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 14,
  parameter int IW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  input  logic [IW-1:0]    pop_idx,
  output logic [W-1:0]     ent_o [DEPTH],
  output logic [DEPTH-1:0] vld_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]     ent_q [DEPTH];
  logic [W-1:0]     ent_d [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [CNTW-1:0]  cnt_q;
  int               tail;

  always_comb begin
    tail = int'(cnt_q) - (pop ? 1 : 0);
    for (int i = 0; i < DEPTH; i++) begin
      if (pop && i >= int'(pop_idx)) begin
        if (i + 1 < DEPTH) begin
          ent_d[i] = ent_q[i+1];
          vld_d[i] = vld_q[i+1];
        end else begin
          ent_d[i] = '0;
          vld_d[i] = 1'b0;
        end
      end else begin
        ent_d[i] = ent_q[i];
        vld_d[i] = vld_q[i];
      end
      if (push && i == tail) begin
        ent_d[i] = push_data;
        vld_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      cnt_q <= cnt_q + CNTW'(push) - CNTW'(pop);
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign ent_o   = ent_q;
  assign vld_o   = vld_q;
  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/sdq_pick.sv
// Chooses the one command for the next cycle: oldest eligible request first,
// otherwise close open banks once the queue is empty.
module sdq_pick
  import sdq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ROW_W = 4,
  parameter int IW    = 2
) (
  input  logic [DEPTH-1:0]  q_vld,
  input  logic [BANK_W-1:0] q_bank [DEPTH],
  input  logic [ROW_W-1:0]  q_row  [DEPTH],
  input  logic [NBANK-1:0]  b_open,
  input  logic [ROW_W-1:0]  b_row  [NBANK],
  input  logic [NBANK-1:0]  b_rdok,
  input  logic [NBANK-1:0]  b_preok,
  output sdq_cmd_e          cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [IW-1:0]     idx_o
);
  logic               found;
  logic               blocked;
  logic [BANK_W-1:0]  b;

  always_comb begin
    cmd_o   = CMD_NOP;
    bank_o  = '0;
    idx_o   = '0;
    found   = 1'b0;
    blocked = 1'b0;
    b       = '0;
    for (int i = 0; i < DEPTH; i++) begin
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j < i && q_vld[j] && q_bank[j] == q_bank[i]) blocked = 1'b1;
      b = q_bank[i];
      if (!found && q_vld[i] && !blocked) begin
        if (b_open[b] && b_row[b] == q_row[i]) begin
          if (b_rdok[b]) begin
            cmd_o = CMD_RD; found = 1'b1;
          end
        end else if (b_open[b]) begin
          if (b_preok[b]) begin
            cmd_o = CMD_PRE; found = 1'b1;
          end
        end else begin
          cmd_o = CMD_ACT; found = 1'b1;
        end
        if (found) begin
          bank_o = b;
          idx_o  = IW'(i);
        end
      end
    end
    if (q_vld == '0) begin
      for (int k = 0; k < NBANK; k++) begin
        if (!found && b_preok[k]) begin
          cmd_o  = CMD_PRE;
          bank_o = BANK_W'(k);
          found  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdq_pkg::*;
#(
  parameter int QDEPTH   = 4,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 4,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 16,
  parameter int T_ACT_RD = 2,
  parameter int T_RD_PRE = 3,
  parameter int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [TAG_W-1:0]  req_tag,
  output logic [1:0]        cmd_o,
  output logic [1:0]        cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  output logic              idle
);
  localparam int EW = BANK_W + ROW_W + COL_W + TAG_W;
  localparam int IW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  // request queue
  logic [EW-1:0]     q_ent  [QDEPTH];
  logic [QDEPTH-1:0] q_vld;
  logic              q_full, q_empty;
  logic [BANK_W-1:0] q_bank [QDEPTH];
  logic [ROW_W-1:0]  q_row  [QDEPTH];
  logic [COL_W-1:0]  q_col  [QDEPTH];
  logic [TAG_W-1:0]  q_tag  [QDEPTH];

  // bank state
  logic [NBANK-1:0]  b_open, b_rdok, b_preok;
  logic [ROW_W-1:0]  b_row [NBANK];

  // scheduler decision
  sdq_cmd_e          pk_cmd;
  logic [BANK_W-1:0] pk_bank;
  logic [IW-1:0]     pk_idx;
  logic [ADDR_W-1:0] pk_addr;
  logic              accept;

  // read return pipeline
  logic              s1_v, s2_v;
  logic [TAG_W-1:0]  s1_tag, s2_tag;

  assign req_ready = !q_full;
  assign accept    = req_valid && req_ready;

  sdq_queue #(.DEPTH(QDEPTH), .W(EW), .IW(IW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .push_data({req_bank, req_row, req_col, req_tag}),
    .pop(pk_cmd == CMD_RD), .pop_idx(pk_idx),
    .ent_o(q_ent), .vld_o(q_vld), .full_o(q_full), .empty_o(q_empty)
  );

  for (genvar i = 0; i < QDEPTH; i++) begin : g_unpack
    assign q_bank[i] = q_ent[i][EW-1 -: BANK_W];
    assign q_row[i]  = q_ent[i][COL_W+TAG_W +: ROW_W];
    assign q_col[i]  = q_ent[i][TAG_W +: COL_W];
    assign q_tag[i]  = q_ent[i][TAG_W-1:0];
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sdq_bank #(.ROW_W(ROW_W), .T_ACT_RD(T_ACT_RD), .T_RD_PRE(T_RD_PRE)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .do_act(pk_cmd == CMD_ACT && pk_bank == BANK_W'(b)),
      .do_rd (pk_cmd == CMD_RD  && pk_bank == BANK_W'(b)),
      .do_pre(pk_cmd == CMD_PRE && pk_bank == BANK_W'(b)),
      .act_row(q_row[pk_idx]),
      .is_open(b_open[b]), .open_row(b_row[b]),
      .rd_ok(b_rdok[b]), .pre_ok(b_preok[b])
    );
  end

  sdq_pick #(.DEPTH(QDEPTH), .ROW_W(ROW_W), .IW(IW)) u_pick (
    .q_vld(q_vld), .q_bank(q_bank), .q_row(q_row),
    .b_open(b_open), .b_row(b_row), .b_rdok(b_rdok), .b_preok(b_preok),
    .cmd_o(pk_cmd), .bank_o(pk_bank), .idx_o(pk_idx)
  );

  always_comb begin
    case (pk_cmd)
      CMD_ACT: pk_addr = ADDR_W'(q_row[pk_idx]);
      CMD_RD:  pk_addr = ADDR_W'(q_col[pk_idx]);
      default: pk_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o      <= CMD_NOP;
      cmd_bank_o <= '0;
      cmd_addr_o <= '0;
      s1_v       <= 1'b0;
      s1_tag     <= '0;
      s2_v       <= 1'b0;
      s2_tag     <= '0;
      rsp_valid  <= 1'b0;
      rsp_tag    <= '0;
      rsp_data   <= '0;
    end else begin
      cmd_o      <= pk_cmd;
      cmd_bank_o <= pk_bank;
      cmd_addr_o <= pk_addr;
      s1_v       <= (pk_cmd == CMD_RD);
      s1_tag     <= q_tag[pk_idx];
      s2_v       <= s1_v;
      s2_tag     <= s1_tag;
      rsp_valid  <= s2_v;
      rsp_tag    <= s2_tag;
      rsp_data   <= rd_data_i;
    end
  end

  assign idle = q_empty && (b_open == '0);
endmodule

// File: rtl/sdq_chk.sv
module sdq_chk
  import sdq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd,
  input logic [1:0] bank,
  input logic       rsp_valid,
  input logic       idle
);
  logic [NBANK-1:0] open_sh, open_now;

  always_comb begin
    open_now = open_sh;
    if (cmd == CMD_ACT) open_now[bank] = 1'b1;
    else if (cmd == CMD_PRE) open_now[bank] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) open_sh <= '0;
    else        open_sh <= open_now;
  end

  // R2
  act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_ACT |-> !open_sh[bank]);

  // R5
  rd_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_RD |-> open_sh[bank]);

  // R6
  pre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_PRE |-> open_sh[bank]);

  // R3
  act_rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_RD |-> !($past(cmd) == CMD_ACT && $past(bank) == bank));

  // R4
  rd_pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_PRE |-> !($past(cmd) == CMD_RD && $past(bank) == bank)
                    && !($past(cmd, 2) == CMD_RD && $past(bank, 2) == bank));

  // R8
  rsp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd, 2) == CMD_RD);

  // R9
  idle_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> open_now == '0);
endmodule

bind sdram_seq sdq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd_o), .bank(cmd_bank_o),
  .rsp_valid(rsp_valid), .idle(idle)
);

// File: tb/sdram_seq_test.sv
`timescale 1ns/1ps
module sdram_seq_test;
  localparam int QD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [3:0]  req_row = '0, req_col = '0, req_tag = '0;
  logic [1:0]  cmd_o, cmd_bank_o;
  logic [3:0]  cmd_addr_o;
  logic [15:0] rd_data_i = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_tag;
  logic [15:0] rsp_data;
  logic        idle;

  always #5 clk = ~clk;

  sdram_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_tag(req_tag),
    .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o),
    .rd_data_i(rd_data_i), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .rsp_data(rsp_data), .idle(idle)
  );

  typedef struct packed {logic [3:0] row; logic [3:0] col; logic [3:0] tag;} rq_t;

  int checks = 0, fails = 0;
  int cyc = 0, accepted = 0, reads = 0, responses = 0;
  int first_cmd = -1, last_cmd = -1, act_n = 0, pre_n = 0;
  bit saw_stall = 1'b0;
  rq_t bq [4][$];
  logic [19:0] expq [$];
  int tag_log [$];
  bit          m_open [4];
  int          m_row [4], act_cyc [4], last_rd [4];
  logic [15:0] pend = '0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mdat(logic [1:0] b, logic [3:0] r, logic [3:0] c);
    return {b, r, c, 6'h2B};
  endfunction

  // memory model and command / response monitor
  always @(negedge clk) begin
    if (rst_n) begin
      rq_t h;
      int b;
      cyc++;
      rd_data_i = pend;
      pend = '0;
      b = int'(cmd_bank_o);
      if (cmd_o != 2'd0) begin
        if (first_cmd < 0) first_cmd = cyc;
        last_cmd = cyc;
      end
      case (cmd_o)
        2'd1: begin
          chk(!m_open[b], "R2", "ACTIVATE to open bank", b, 0);
          m_open[b] = 1; m_row[b] = int'(cmd_addr_o); act_cyc[b] = cyc; last_rd[b] = -100;
          act_n++;
        end
        2'd2: begin
          chk(m_open[b], "R5", "READ to closed bank", b, 1);
          chk(cyc - act_cyc[b] >= 2, "R3", "ACT to READ gap", cyc - act_cyc[b], 2);
          if (bq[b].size() == 0) chk(0, "R7", "READ with no request for bank", b, 0);
          else begin
            h = bq[b].pop_front();
            chk(int'(h.row) == m_row[b], "R5", "READ row", m_row[b], int'(h.row));
            chk(cmd_addr_o == h.col, "R7", "READ column", int'(cmd_addr_o), int'(h.col));
            expq.push_back({h.tag, mdat(cmd_bank_o, h.row, h.col)});
            pend = mdat(cmd_bank_o, h.row, h.col);
          end
          last_rd[b] = cyc;
          reads++;
        end
        2'd3: begin
          chk(m_open[b], "R6", "PRECHARGE to closed bank", b, 1);
          chk(cyc - last_rd[b] >= 3, "R4", "READ to PRE gap", cyc - last_rd[b], 3);
          m_open[b] = 0;
          pre_n++;
        end
        default: ;
      endcase
      if (rsp_valid) begin
        responses++;
        tag_log.push_back(int'(rsp_tag));
        if (expq.size() == 0) chk(0, "R8", "unexpected response", int'(rsp_tag), -1);
        else begin
          logic [19:0] e;
          e = expq.pop_front();
          chk(rsp_tag == e[19:16], "R8", "response tag", int'(rsp_tag), int'(e[19:16]));
          chk(rsp_data == e[15:0], "R8", "response data", int'(rsp_data), int'(e[15:0]));
        end
      end
    end
  end

  task automatic push(logic [1:0] b, logic [3:0] r, logic [3:0] c, logic [3:0] t);
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = c; req_tag = t;
    #1;
    chk(req_ready == ((accepted - reads) < QD), "R1", "ready vs queue fill",
        int'(req_ready), int'((accepted - reads) < QD));
    while (!req_ready) begin
      saw_stall = 1'b1;
      @(negedge clk); #1;
    end
    @(posedge clk);
    bq[b].push_back('{row: r, col: c, tag: t});
    accepted++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (!(idle && expq.size() == 0 && accepted == reads)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic span_start();
    first_cmd = -1; last_cmd = -1; act_n = 0; pre_n = 0;
    tag_log.delete();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; m_row[i] = 0; act_cyc[i] = -100; last_rd[i] = -100;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(cmd_o == 2'd0, "R11", "cmd in reset", int'(cmd_o), 0);
    chk(idle == 1'b1, "R11", "idle in reset", int'(idle), 1);
    chk(req_ready == 1'b1, "R11", "ready in reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 R10: four rows of bank 0
    span_start();
    for (int i = 0; i < 4; i++) push(2'd0, 4'(i + 1), 4'(i), 4'(i));
    drain();
    chk(last_cmd - first_cmd + 1 == 24, "R10", "span four rows bank0", last_cmd - first_cmd + 1, 24);
    chk(act_n == 4, "R6", "ACT count four rows", act_n, 4);
    chk(pre_n == 4, "R6", "PRE count four rows", pre_n, 4);

    // R5 R7 R10: alternating banks 0/1, same row each
    span_start();
    push(2'd0, 4'd5, 4'd1, 4'd0);
    push(2'd1, 4'd6, 4'd2, 4'd1);
    push(2'd0, 4'd5, 4'd3, 4'd2);
    push(2'd1, 4'd6, 4'd4, 4'd3);
    drain();
    chk(last_cmd - first_cmd + 1 == 9, "R10", "span two banks", last_cmd - first_cmd + 1, 9);
    chk(act_n == 2, "R5", "row hit needs no ACT", act_n, 2);
    for (int i = 0; i < 4; i++)
      chk(tag_log.size() > i && tag_log[i] == i, "R7", "oldest-first tag order",
          (tag_log.size() > i) ? tag_log[i] : -1, i);

    // R9 R10: one read in each bank
    span_start();
    for (int i = 0; i < 4; i++) push(2'(i), 4'(i + 2), 4'(i), 4'(i + 8));
    drain();
    chk(last_cmd - first_cmd + 1 == 12, "R10", "span four banks", last_cmd - first_cmd + 1, 12);
    chk(pre_n == 4, "R9", "all banks closed at drain", pre_n, 4);
    chk(idle == 1'b1, "R9", "idle after drain", int'(idle), 1);

    // R1: same-bank row conflicts fill the queue
    saw_stall = 1'b0;
    for (int i = 0; i < 7; i++) push(2'd2, 4'(i % 2), 4'(i), 4'(i));
    chk(saw_stall, "R1", "back-pressure seen when full", int'(saw_stall), 1);
    drain();

    // R7 R8: random mix with gaps
    for (int i = 0; i < 60; i++) begin
      push(2'($urandom_range(0, 3)), 4'($urandom_range(0, 2)),
           4'($urandom_range(0, 15)), 4'(i % 16));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    drain();
    chk(responses == accepted, "R8", "one response per request", responses, accepted);
    chk(idle == 1'b1, "R9", "idle at end", int'(idle), 1);
    for (int i = 0; i < 4; i++)
      chk(!m_open[i], "R9", "bank closed at end", int'(m_open[i]), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule